// File: doc/BRIEF.md
# Interrupt Pin Front-End

This block sits between the two external interrupt pins of a processor core and the core itself. Both pins arrive with no relation to the core clock, so each one is first passed through a short chain of flip-flops. The maskable pin is treated as a level. When it is seen high and the core's interrupt-enable flag is set, the block runs a pair of locked interrupt-acknowledge bus cycles. It tells the core the interrupt is real only if the pin was still high when the second cycle ended.

The non-maskable pin is treated as an edge. A rising edge is accepted only if the synchronized pin had been low for a minimum number of clocks just before it. An accepted edge sets a pending flag. The flag stays set until the core acknowledges it. While it is set, no new maskable acknowledge sequence may begin.

Top module: `irq_pin_front`

## Requirements
- R1: After a synchronous reset, every output (`nmi_pending_o`, `intr_req_o`, `ack_req_o`, `ack_second_o`, `ack_lock_o`) is 0.
- R2: A maskable sequence starts only from idle, with `if_flag_i` high and the synchronized maskable pin high. A change on `intr_pin_i` reaches `ack_req_o` after three clock edges: two synchronizer stages and the state register. With `if_flag_i` low, no acknowledge cycle starts.
- R3: `intr_req_o` is a single-cycle pulse. It is high only while the second acknowledge cycle is active and `bus_rdy_i` is high. It is high only if the synchronized maskable pin stayed high for the whole sequence; a pin that drops early gives no pulse.
- R4: Each sequence consists of exactly two acknowledge cycles, and each advances on `bus_rdy_i`. `ack_second_o` is 0 during the first cycle and 1 during the second. Both cycles run to completion even if the pin drops.
- R5: `ack_lock_o` is high throughout both acknowledge cycles. It is low from the clock edge at which `bus_rdy_i` ends the second cycle.
- R6: A rising edge on the synchronized non-maskable pin sets `nmi_pending_o` only if that pin was low for at least `NMI_LOW_MIN` (default 4) consecutive clocks before it. With a long low time, `nmi_pending_o` rises three clock edges after `nmi_pin_i` rises.
- R7: A rising edge that follows fewer than `NMI_LOW_MIN` low clocks is ignored, and `nmi_pending_o` stays 0.
- R8: `nmi_pending_o` holds until a `nmi_ack_i` pulse and is 0 on the next cycle. A pin that simply stays high does not set the flag again.
- R9: While `nmi_pending_o` is high, no maskable acknowledge sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| intr_pin_i | input | 1 | Maskable interrupt pin, asynchronous, level |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin, asynchronous, rising edge |
| if_flag_i | input | 1 | Core interrupt-enable flag |
| bus_rdy_i | input | 1 | Ready that ends the current acknowledge bus cycle |
| nmi_ack_i | input | 1 | Core acknowledge that clears the non-maskable pending flag |
| nmi_pending_o | output | 1 | Non-maskable interrupt pending |
| intr_req_o | output | 1 | One-cycle pulse: maskable interrupt recognized |
| ack_req_o | output | 1 | Interrupt-acknowledge bus cycle requested |
| ack_second_o | output | 1 | 0 = first acknowledge cycle, 1 = second |
| ack_lock_o | output | 1 | Lock qualifier for the acknowledge pair |

## Verification
The bench tests a non-maskable low time of exactly the minimum and one clock less. A counter that is off by one would accept the short pulse or reject the exact one. It also holds the non-maskable pin high after an acknowledge, because a design that detects the level instead of the edge would set the flag again. On the maskable side, the pin is dropped halfway through the pair. A design that latches the request at the start would still pulse `intr_req_o`, and one that aborts would skip the second locked cycle. A pending non-maskable interrupt is shown to hold off a ready maskable request. Without that priority, the acknowledge cycles would start early.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_SECOND = 2'd2
    } ack_state_e;

    typedef struct packed {
        logic req;
        logic second;
        logic lock;
    } ack_bus_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic ack_bus_t bus_of_state(input ack_state_e st);
        ack_bus_t b;
        b.req    = (st != ACK_IDLE);
        b.second = (st == ACK_SECOND);
        b.lock   = (st != ACK_IDLE);
        return b;
    endfunction

endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqfe_nmi_qual.sv
module irqfe_nmi_qual
    import irqfe_pkg::*;
#(
    parameter int LOW_MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic nmi_s_i,
    input  logic nmi_ack_i,
    output logic pending_o
);
    localparam int CW = cnt_width(LOW_MIN);
    localparam logic [CW-1:0] LIMIT = CW'(LOW_MIN);

    logic [CW-1:0] low_cnt;
    logic          edge_ok;
    logic          pending_q;

    // Saturating count of consecutive low samples; a high sample clears it.
    always_ff @(posedge clk) begin
        if (rst)                 low_cnt <= '0;
        else if (nmi_s_i)        low_cnt <= '0;
        else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
    end

    // A high sample with a full count is the first high after a long low.
    assign edge_ok = nmi_s_i && (low_cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst)            pending_q <= 1'b0;
        else if (edge_ok)   pending_q <= 1'b1;
        else if (nmi_ack_i) pending_q <= 1'b0;
    end

    assign pending_o = pending_q;
endmodule

// File: rtl/irqfe_ack_seq.sv
module irqfe_ack_seq
    import irqfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     intr_s_i,
    input  logic     if_flag_i,
    input  logic     nmi_pending_i,
    input  logic     bus_rdy_i,
    output ack_bus_t bus_o,
    output logic     taken_o
);
    ack_state_e state_q, state_d;
    logic       dropped_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:
                if (intr_s_i && if_flag_i && !nmi_pending_i) state_d = ACK_FIRST;
            ACK_FIRST:
                if (bus_rdy_i) state_d = ACK_SECOND;
            ACK_SECOND:
                if (bus_rdy_i) state_d = ACK_IDLE;
            default:
                state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ACK_IDLE;
        else     state_q <= state_d;
    end

    // Remembers whether the request fell at any point of the pair.
    always_ff @(posedge clk) begin
        if (rst || state_q == ACK_IDLE) dropped_q <= 1'b0;
        else if (!intr_s_i)             dropped_q <= 1'b1;
    end

    assign bus_o   = bus_of_state(state_q);
    assign taken_o = (state_q == ACK_SECOND) && bus_rdy_i && intr_s_i && !dropped_q;
endmodule

// File: rtl/irq_pin_front.sv
module irq_pin_front
    import irqfe_pkg::*;
#(
    parameter int NMI_LOW_MIN = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic intr_pin_i,
    input  logic nmi_pin_i,
    input  logic if_flag_i,
    input  logic bus_rdy_i,
    input  logic nmi_ack_i,
    output logic nmi_pending_o,
    output logic intr_req_o,
    output logic ack_req_o,
    output logic ack_second_o,
    output logic ack_lock_o
);
    logic [1:0] pins_s;
    logic       pending;
    ack_bus_t   bus;

    irqfe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({nmi_pin_i, intr_pin_i}),
        .q_o (pins_s)
    );

    irqfe_nmi_qual #(.LOW_MIN(NMI_LOW_MIN)) u_nmi (
        .clk       (clk),
        .rst       (rst),
        .nmi_s_i   (pins_s[1]),
        .nmi_ack_i (nmi_ack_i),
        .pending_o (pending)
    );

    irqfe_ack_seq u_ack (
        .clk           (clk),
        .rst           (rst),
        .intr_s_i      (pins_s[0]),
        .if_flag_i     (if_flag_i),
        .nmi_pending_i (pending),
        .bus_rdy_i     (bus_rdy_i),
        .bus_o         (bus),
        .taken_o       (intr_req_o)
    );

    assign nmi_pending_o = pending;
    assign ack_req_o     = bus.req;
    assign ack_second_o  = bus.second;
    assign ack_lock_o    = bus.lock;
endmodule

// File: rtl/irqfe_checker.sv
module irqfe_checker (
    input logic clk,
    input logic rst,
    input logic if_flag_i,
    input logic bus_rdy_i,
    input logic nmi_ack_i,
    input logic nmi_pending_o,
    input logic intr_req_o,
    input logic ack_req_o,
    input logic ack_second_o,
    input logic ack_lock_o
);
    // R5: lock covers every acknowledge cycle
    a_r5_lock_during_ack: assert property (@(posedge clk) disable iff (rst)
        ack_req_o |-> ack_lock_o);

    // R5: lock released after ready ends the second cycle
    a_r5_lock_release: assert property (@(posedge clk) disable iff (rst)
        (ack_req_o && ack_second_o && bus_rdy_i) |=> (!ack_req_o && !ack_lock_o));

    // R4: the first cycle is always followed by the second
    a_r4_second_follows: assert property (@(posedge clk) disable iff (rst)
        (ack_req_o && !ack_second_o && bus_rdy_i) |=> (ack_req_o && ack_second_o));

    // R3: recognition only at the end of the second cycle
    a_r3_req_at_end: assert property (@(posedge clk) disable iff (rst)
        intr_req_o |-> (ack_req_o && ack_second_o && bus_rdy_i));

    // R8: pending holds until acknowledged
    a_r8_pending_holds: assert property (@(posedge clk) disable iff (rst)
        (nmi_pending_o && !nmi_ack_i) |=> nmi_pending_o);

    // R9: pending non-maskable interrupt blocks a new sequence
    a_r9_nmi_priority: assert property (@(posedge clk) disable iff (rst)
        (!ack_req_o && nmi_pending_o) |=> !ack_req_o);

    // R2: no sequence starts with the enable flag clear
    a_r2_if_gate: assert property (@(posedge clk) disable iff (rst)
        (!ack_req_o && !if_flag_i) |=> !ack_req_o);
endmodule

bind irq_pin_front irqfe_checker u_irqfe_checker (
    .clk           (clk),
    .rst           (rst),
    .if_flag_i     (if_flag_i),
    .bus_rdy_i     (bus_rdy_i),
    .nmi_ack_i     (nmi_ack_i),
    .nmi_pending_o (nmi_pending_o),
    .intr_req_o    (intr_req_o),
    .ack_req_o     (ack_req_o),
    .ack_second_o  (ack_second_o),
    .ack_lock_o    (ack_lock_o)
);

// File: tb/test_irq_pin_front.sv
`timescale 1ns/1ps
module test_irq_pin_front;
    logic clk = 1'b0;
    logic rst, intr_pin, nmi_pin, if_flag, bus_rdy, nmi_ack;
    logic nmi_pending, intr_req, ack_req, ack_second, ack_lock;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_pin_front i_irq_pin_front (
        .clk           (clk),
        .rst           (rst),
        .intr_pin_i    (intr_pin),
        .nmi_pin_i     (nmi_pin),
        .if_flag_i     (if_flag),
        .bus_rdy_i     (bus_rdy),
        .nmi_ack_i     (nmi_ack),
        .nmi_pending_o (nmi_pending),
        .intr_req_o    (intr_req),
        .ack_req_o     (ack_req),
        .ack_second_o  (ack_second),
        .ack_lock_o    (ack_lock)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; intr_pin = 1'b0; nmi_pin = 1'b0; if_flag = 1'b0;
        bus_rdy = 1'b0; nmi_ack = 1'b0;
        step(3);
        rst = 1'b0;
        #1;
        chk("R1", "nmi_pending", nmi_pending, 1'b0);
        chk("R1", "intr_req", intr_req, 1'b0);
        chk("R1", "ack_req", ack_req, 1'b0);
        chk("R1", "ack_second", ack_second, 1'b0);
        chk("R1", "ack_lock", ack_lock, 1'b0);
        step(6);
    endtask

    task automatic ack_nmi();
        nmi_ack = 1'b1;
        step(1);
        nmi_ack = 1'b0;
        #1 chk("R8", "pending cleared by ack", nmi_pending, 1'b0);
    endtask

    task automatic t_nmi_long_low();
        nmi_pin = 1'b1;
        step(2);
        #1 chk("R6", "pending before latency", nmi_pending, 1'b0);
        step(1);
        #1 chk("R6", "pending after three edges", nmi_pending, 1'b1);
        step(5);
        #1 chk("R8", "pending holds without ack", nmi_pending, 1'b1);
        ack_nmi();
        step(6);
        #1 chk("R8", "held-high pin does not retrigger", nmi_pending, 1'b0);
    endtask

    task automatic t_nmi_short_low();
        nmi_pin = 1'b0;
        step(3);
        nmi_pin = 1'b1;
        step(6);
        #1 chk("R7", "edge after three low clocks ignored", nmi_pending, 1'b0);
        nmi_pin = 1'b0;
        step(4);
        nmi_pin = 1'b1;
        step(3);
        #1 chk("R6", "edge after exactly four low clocks", nmi_pending, 1'b1);
        nmi_pin = 1'b0;
        ack_nmi();
        step(6);
    endtask

    task automatic t_intr_masked();
        if_flag = 1'b0;
        intr_pin = 1'b1;
        step(8);
        #1 chk("R2", "no ack with enable clear", ack_req, 1'b0);
        chk("R2", "no lock with enable clear", ack_lock, 1'b0);
        intr_pin = 1'b0;
        step(4);
    endtask

    // Runs from the first acknowledge cycle; core clears IF on recognition.
    task automatic finish_pair(input logic exp_req, input string req);
        bus_rdy = 1'b1;
        #1 chk("R3", "no recognition in first cycle", intr_req, 1'b0);
        step(1);
        #1 chk("R4", "second cycle flagged", ack_second, 1'b1);
        chk("R4", "second cycle requested", ack_req, 1'b1);
        chk("R5", "lock in second cycle", ack_lock, 1'b1);
        chk(req, "recognition at end of pair", intr_req, exp_req);
        if_flag = 1'b0;
        intr_pin = 1'b0;
        step(1);
        bus_rdy = 1'b0;
        #1 chk("R5", "lock released after pair", ack_lock, 1'b0);
        chk("R4", "exactly two cycles", ack_req, 1'b0);
        chk("R3", "pulse is single cycle", intr_req, 1'b0);
        step(4);
    endtask

    task automatic t_intr_full();
        if_flag = 1'b1;
        intr_pin = 1'b1;
        step(2);
        #1 chk("R2", "ack not before sync latency", ack_req, 1'b0);
        step(1);
        #1 chk("R2", "ack after three edges", ack_req, 1'b1);
        chk("R4", "first cycle flagged", ack_second, 1'b0);
        chk("R5", "lock in first cycle", ack_lock, 1'b1);
        finish_pair(1'b1, "R3");
    endtask

    task automatic t_intr_dropped();
        if_flag = 1'b1;
        intr_pin = 1'b1;
        step(3);
        #1 chk("R2", "dropped test: ack started", ack_req, 1'b1);
        intr_pin = 1'b0;
        step(4);
        #1 chk("R4", "first cycle waits for ready", ack_req, 1'b1);
        chk("R4", "still first cycle", ack_second, 1'b0);
        finish_pair(1'b0, "R3");
    endtask

    task automatic t_priority();
        nmi_pin = 1'b1;
        step(4);
        #1 chk("R6", "priority test: pending set", nmi_pending, 1'b1);
        if_flag = 1'b1;
        intr_pin = 1'b1;
        step(6);
        #1 chk("R9", "maskable held off while pending", ack_req, 1'b0);
        nmi_ack = 1'b1;
        step(1);
        nmi_ack = 1'b0;
        step(1);
        #1 chk("R9", "maskable starts after ack", ack_req, 1'b1);
        finish_pair(1'b1, "R3");
        nmi_pin = 1'b0;
        step(6);
    endtask

    initial begin
        t_reset();
        t_nmi_long_low();
        t_nmi_short_low();
        t_intr_masked();
        t_intr_full();
        t_intr_dropped();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule